// File: doc/BRIEF.md
# Addressed Serial Multi-Channel Latch Loader

This block is the digital control core of a multi-channel programmable resistor. A host drives a three-wire serial port: a serial clock, an active-low chip select and a data line. All three are sampled by a faster system clock. While chip select is low, every rising edge of the serial clock shifts one bit into an 11-bit register. A frame carries a 3-bit channel address, most significant bit first, followed by an 8-bit setting, also most significant bit first. When chip select rises, the most recent 11 bits are decoded and the setting is written into the addressed channel latch only.

The oldest stored bit is driven on a serial output, so several devices can be chained under one chip-select period. In a chain, the device farthest from the host receives the first frame sent. An asynchronous active-low preset and the power-on reset put every latch at midscale. A shutdown input keeps the latch contents, forces the serial output high and raises a per-channel status flag. An analog model downstream uses that flag to open terminal A and tie the wiper to terminal B.

Top module: `serpot_ctrl`

## Requirements
- R1: A frame is 11 bits sent in the order address bit 2, address bit 1, address bit 0, then data bit 7 down to data bit 0. On chip-select release, address value k writes the data byte into channel latch k, which appears on `chan_val_o[8k+7:8k]`.
- R2: A bit is shifted in only on a rising serial-clock edge while chip select is low. If more than 11 bits are sent, the last 11 form the frame.
- R3: A commit changes no latch other than the addressed one. A latch changes only on a commit, a preset or a reset.
- R4: Address values equal to or above the channel count `NCH` write no latch. With `NCH`=4 these are 4 to 7; with `NCH`=6 they are 6 and 7.
- R5: `sdo_o` shows the oldest of the 11 stored bits. After the 11th shift of a frame it equals the frame's first bit. In a two-device chain, a 22-bit frame under one chip-select period loads the far device with the first 11 bits and the near device with the last 11 bits.
- R6: While `preset_n_i` is low, every latch reads 0x80, asynchronously. The shift register is also cleared, so `sdo_o` reads 0 when not in shutdown.
- R7: After power-on reset, every latch reads 0x80, `sdo_o` is 0 and `chan_off_o` is all zeros.
- R8: While chip select is high, serial-clock edges leave both the shift register and `sdo_o` unchanged.
- R9: While `shdn_n_i` is low, `sdo_o` is 1, every bit of `chan_off_o` is 1 and the latch values are kept. On release, `sdo_o` returns to the stored bit and `chan_off_o` to zeros.
- R10: A preset overlapping a chip-select release wins: no channel takes the frame's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial port |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| sclk_i | input | 1 | Serial clock; rising edges shift |
| csn_i | input | 1 | Active-low chip select; the rising edge commits |
| sdi_i | input | 1 | Serial data in |
| preset_n_i | input | 1 | Active-low asynchronous preset to midscale |
| shdn_n_i | input | 1 | Active-low shutdown |
| sdo_o | output | 1 | Serial data out for chaining; high in shutdown |
| chan_val_o | output | NCH*DATA_W | Channel latch values, channel 0 in the low byte |
| chan_off_o | output | NCH | Per-channel shutdown status |

## Verification
A corrupted shift register shows up on `sdo_o` within the synchronizer delay after the next serial-clock edge. It also shows up in the latch written at the following chip-select release. A wrong address decode writes the wrong byte lane or a lane that should be untouched, and this can be seen a few system clocks after the release. A lost or wrongly applied preset appears at once as a non-midscale value, while preset is still held. A wrong shutdown path shows within the shutdown synchronizer delay as a low `sdo_o` or a cleared status bit.

// File: rtl/serpot_pkg.sv
package serpot_pkg;
   localparam int unsigned DFLT_ADDR_W = 3;
   localparam int unsigned DFLT_DATA_W = 8;
   localparam int unsigned DFLT_NCH    = 6;
   localparam int unsigned DFLT_SYNC   = 2;
   // bit order of the sampled input vector
   localparam int unsigned SMP_SDI  = 0;
   localparam int unsigned SMP_SCLK = 1;
   localparam int unsigned SMP_CSN  = 2;
   localparam int unsigned SMP_SHDN = 3;
   localparam int unsigned SMP_W    = 4;
endpackage

// File: rtl/serpot_sampler.sv
module serpot_sampler
   import serpot_pkg::*;
#(
   parameter int unsigned STAGES = DFLT_SYNC
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic csn_i,
   input  logic sdi_i,
   input  logic shdn_n_i,
   output logic sclk_rise,
   output logic cs_rise,
   output logic csn_s,
   output logic sdi_s,
   output logic shdn_act
);
   // idle levels: shutdown released, chip select high, clock low, data low
   localparam logic [SMP_W-1:0] IDLE = 4'b1100;

   logic [STAGES-1:0][SMP_W-1:0] stg_q;
   logic [SMP_W-1:0]             raw;
   logic [SMP_W-1:0]             smp;
   logic                         sclk_d, csn_d;

   assign raw = {shdn_n_i, csn_i, sclk_i, sdi_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= {STAGES{IDLE}};
      end else begin
         stg_q[0] <= raw;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign smp = stg_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         csn_d  <= 1'b1;
      end else begin
         sclk_d <= smp[SMP_SCLK];
         csn_d  <= smp[SMP_CSN];
      end
   end

   assign sclk_rise = smp[SMP_SCLK] & ~sclk_d;
   assign cs_rise   = smp[SMP_CSN] & ~csn_d;
   assign csn_s     = smp[SMP_CSN];
   assign sdi_s     = smp[SMP_SDI];
   assign shdn_act  = ~smp[SMP_SHDN];
endmodule

// File: rtl/serpot_shreg.sv
module serpot_shreg #(
   parameter int unsigned W = 11
) (
   input  logic         clk,
   input  logic         clr_n,
   input  logic         shift_en,
   input  logic         din,
   input  logic         force_hi,
   output logic [W-1:0] sr_q,
   output logic         sdo
);
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)        sr_q <= '0;
      else if (shift_en) sr_q <= {sr_q[W-2:0], din};
   end

   // oldest stored bit goes out; the next device samples it before this shift
   assign sdo = force_hi | sr_q[W-1];
endmodule

// File: rtl/serpot_latch_bank.sv
module serpot_latch_bank #(
   parameter int unsigned NCH    = 6,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     clr_n,
   input  logic                     commit,
   input  logic [ADDR_W+DATA_W-1:0] frame,
   output logic [NCH*DATA_W-1:0]    vals_o
);
   localparam int unsigned         FRAME_W  = ADDR_W + DATA_W;
   localparam logic [DATA_W-1:0]   MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};
   localparam bit                  FULL_MAP = (NCH == (1 << ADDR_W));

   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] code;
   logic              addr_ok;
   logic [NCH-1:0]    hit;

   assign addr = frame[FRAME_W-1 -: ADDR_W];
   assign code = frame[DATA_W-1:0];

   generate
      if (FULL_MAP) begin : g_full
         assign addr_ok = 1'b1;
      end else begin : g_part
         assign addr_ok = (int'(addr) < NCH);
      end
   endgenerate

   genvar ch;
   generate
      for (ch = 0; ch < NCH; ch++) begin : g_ch
         logic [DATA_W-1:0] q;
         assign hit[ch] = commit & addr_ok & (addr == ADDR_W'(ch));
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)       q <= MID_CODE;
            else if (hit[ch]) q <= code;
         end
         assign vals_o[ch*DATA_W +: DATA_W] = q;
      end
   endgenerate
endmodule

// File: rtl/serpot_ctrl.sv
module serpot_ctrl
   import serpot_pkg::*;
#(
   parameter int unsigned NCH         = DFLT_NCH,
   parameter int unsigned ADDR_W      = DFLT_ADDR_W,
   parameter int unsigned DATA_W      = DFLT_DATA_W,
   parameter int unsigned SYNC_STAGES = DFLT_SYNC
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk_i,
   input  logic                  csn_i,
   input  logic                  sdi_i,
   input  logic                  preset_n_i,
   input  logic                  shdn_n_i,
   output logic                  sdo_o,
   output logic [NCH*DATA_W-1:0] chan_val_o,
   output logic [NCH-1:0]        chan_off_o
);
   localparam int unsigned FRAME_W = ADDR_W + DATA_W;

   generate
      if (NCH < 1 || NCH > (1 << ADDR_W)) begin : g_bad_nch
         $error("serpot_ctrl: NCH must lie in 1 .. 2**ADDR_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serpot_ctrl: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("serpot_ctrl: DATA_W must be at least 2");
      end
   endgenerate

   logic               sclk_rise, cs_rise, csn_s, sdi_s, shdn_act;
   logic               clr_n;
   logic [FRAME_W-1:0] sr_q;

   // preset and power-on reset share the asynchronous clear; preset wins over commit
   assign clr_n = rst_n & preset_n_i;

   serpot_sampler #(.STAGES(SYNC_STAGES)) smp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk_i),
      .csn_i     (csn_i),
      .sdi_i     (sdi_i),
      .shdn_n_i  (shdn_n_i),
      .sclk_rise (sclk_rise),
      .cs_rise   (cs_rise),
      .csn_s     (csn_s),
      .sdi_s     (sdi_s),
      .shdn_act  (shdn_act)
   );

   serpot_shreg #(.W(FRAME_W)) sr_i (
      .clk      (clk),
      .clr_n    (clr_n),
      .shift_en (sclk_rise & ~csn_s),
      .din      (sdi_s),
      .force_hi (shdn_act),
      .sr_q     (sr_q),
      .sdo      (sdo_o)
   );

   serpot_latch_bank #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) bank_i (
      .clk    (clk),
      .clr_n  (clr_n),
      .commit (cs_rise),
      .frame  (sr_q),
      .vals_o (chan_val_o)
   );

   genvar ch;
   generate
      for (ch = 0; ch < NCH; ch++) begin : g_off
         assign chan_off_o[ch] = shdn_act;
      end
   endgenerate
endmodule

// File: rtl/serpot_ctrl_chk.sv
module serpot_ctrl_chk #(
   parameter int unsigned NCH    = 6,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      preset_n_i,
   input logic                      csn_s,
   input logic                      sclk_rise,
   input logic                      cs_rise,
   input logic                      sdi_s,
   input logic [ADDR_W+DATA_W-1:0]  sr_q,
   input logic [NCH*DATA_W-1:0]     chan_val_o,
   input logic [NCH-1:0]            chan_off_o,
   input logic                      sdo_o
);
   localparam int unsigned       FRAME_W  = ADDR_W + DATA_W;
   localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

   p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n || !preset_n_i)
      (sclk_rise && !csn_s) |=> (sr_q[0] == $past(sdi_s)));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || !preset_n_i)
      !cs_rise |=> $stable(chan_val_o));

   p_bad_addr_r4: assert property (@(posedge clk) disable iff (!rst_n || !preset_n_i)
      (cs_rise && int'(sr_q[FRAME_W-1 -: ADDR_W]) >= NCH) |=> $stable(chan_val_o));

   p_chain_r5: assert property (@(posedge clk) disable iff (!rst_n || !preset_n_i)
      (sclk_rise && !csn_s && !chan_off_o[0]) |=>
         (chan_off_o[0] || sdo_o == $past(sr_q[FRAME_W-2])));

   p_preset_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !preset_n_i |-> (chan_val_o == {NCH{MID_CODE}}));

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n || !preset_n_i)
      csn_s |=> $stable(sr_q));

   p_shdn_sdo_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chan_off_o[0] |-> sdo_o);
endmodule

bind serpot_ctrl serpot_ctrl_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .preset_n_i (preset_n_i),
   .csn_s      (csn_s),
   .sclk_rise  (sclk_rise),
   .cs_rise    (cs_rise),
   .sdi_s      (sdi_s),
   .sr_q       (sr_q),
   .chan_val_o (chan_val_o),
   .chan_off_o (chan_off_o),
   .sdo_o      (sdo_o)
);

// File: tb/serpot_ctrl_tb_top.sv
`timescale 1ns/1ps
module serpot_ctrl_tb_top;
   localparam int NA = 6;
   localparam int NB = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, preset_n = 1'b1, shdn_n = 1'b1;
   logic sdo_a, sdo_b;
   logic [NA*8-1:0] val_a;
   logic [NB*8-1:0] val_b;
   logic [NA-1:0]   off_a;
   logic [NB-1:0]   off_b;

   int n_chk = 0, n_fail = 0;
   int exp_a[NA];
   int exp_b[NB];
   bit done = 0;

   always #2 clk = ~clk;

   serpot_ctrl #(.NCH(NA)) dut_i (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
      .preset_n_i(preset_n), .shdn_n_i(shdn_n), .sdo_o(sdo_a),
      .chan_val_o(val_a), .chan_off_o(off_a));

   // chained device fed from the first one's serial output
   serpot_ctrl #(.NCH(NB)) dut_chain_i (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdo_a),
      .preset_n_i(preset_n), .shdn_n_i(shdn_n), .sdo_o(sdo_b),
      .chan_val_o(val_b), .chan_off_o(off_b));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic shift_bit(input logic b);
      sdi = b;
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      tick(2);
   endtask

   task automatic shift_frame(input int addr, input int code);
      logic [10:0] f;
      f = {addr[2:0], code[7:0]};
      for (int i = 10; i >= 0; i--) shift_bit(f[i]);
   endtask

   task automatic cs_low;
      csn = 1'b0;
      tick(4);
   endtask

   task automatic cs_high;
      tick(4);
      csn = 1'b1;
      tick(10);
   endtask

   task automatic send(input int addr, input int code);
      cs_low();
      shift_frame(addr, code);
      cs_high();
      if (addr < NA) exp_a[addr] = code;
   endtask

   task automatic check_a(input string req);
      for (int c = 0; c < NA; c++) chk(req, int'(val_a[c*8 +: 8]), exp_a[c]);
   endtask

   task automatic check_b(input string req);
      for (int c = 0; c < NB; c++) chk(req, int'(val_b[c*8 +: 8]), exp_b[c]);
   endtask

   task automatic do_preset;
      preset_n = 1'b0;
      tick(3);
      for (int c = 0; c < NA; c++) exp_a[c] = 8'h80;
      for (int c = 0; c < NB; c++) exp_b[c] = 8'h80;
      check_a("R6 preset");
      chk("R6 sdo cleared", int'(sdo_a), 0);
      preset_n = 1'b1;
      tick(3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [13:0] bits;
      for (int c = 0; c < NA; c++) exp_a[c] = 8'h80;
      for (int c = 0; c < NB; c++) exp_b[c] = 8'h80;
      tick(3);
      rst_n = 1'b1;
      tick(3);

      // R7 reset state
      check_a("R7 reset");
      check_b("R7 reset chain");
      chk("R7 sdo", int'(sdo_a), 0);
      chk("R7 off", int'(off_a), 0);

      // R1 R3 R4: every address, arithmetic patterns
      for (int a = 0; a < 8; a++) begin
         send(a, (a * 53 + 17) & 8'hFF);
         check_a(a < NA ? "R1 R3 address sweep" : "R4 invalid address");
      end

      // R1: every code value, rotating over the channels
      for (int v = 0; v < 256; v++) begin
         send(v % NA, v);
         chk("R1 code sweep", int'(val_a[(v % NA)*8 +: 8]), v);
      end
      check_a("R3 after code sweep");

      // R2 R5: 14 bits, last 11 form the frame; sdo trails by 10 shifts
      bits = {3'b101, 3'b010, 8'hC3};
      cs_low();
      for (int k = 0; k < 14; k++) begin
         shift_bit(bits[13-k]);
         if (k >= 10) chk("R5 sdo trails input", int'(sdo_a), int'(bits[13-(k-10)]));
      end
      cs_high();
      exp_a[2] = 8'hC3;
      check_a("R2 last eleven bits");
      chk("R5 sdo first frame bit", int'(sdo_a), 0);

      // R8: clocks with chip select high do nothing
      sdi = 1'b1;
      for (int k = 0; k < 5; k++) begin
         tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
      end
      tick(4);
      chk("R8 sdo unchanged", int'(sdo_a), 0);
      cs_low();
      cs_high();
      check_a("R8 register unchanged");

      // R9 shutdown keeps values, forces sdo high
      send(1, 8'h3C);
      shdn_n = 1'b0;
      tick(6);
      chk("R9 sdo high", int'(sdo_a), 1);
      chk("R9 off flags", int'(off_a), (1 << NA) - 1);
      check_a("R9 values kept");
      shdn_n = 1'b1;
      tick(6);
      chk("R9 sdo restored", int'(sdo_a), 0);
      chk("R9 off cleared", int'(off_a), 0);
      check_a("R9 values after release");

      // R6 preset
      do_preset();
      check_a("R6 after preset release");

      // R10 preset overlapping a commit
      cs_low();
      shift_frame(1, 8'h5A);
      tick(4);
      preset_n = 1'b0;
      csn = 1'b1;
      tick(10);
      preset_n = 1'b1;
      tick(6);
      check_a("R10 preset beats commit");

      // R5 two-device chain, 22-bit frame
      do_preset();
      cs_low();
      shift_frame(3, 8'h9C);
      shift_frame(5, 8'h2E);
      cs_high();
      exp_b[3] = 8'h9C;
      exp_a[5] = 8'h2E;
      check_b("R5 chain far device");
      check_a("R5 chain near device");

      // R4 on the four-channel variant through the chain
      cs_low();
      shift_frame(4, 8'h33);
      shift_frame(0, 8'h44);
      cs_high();
      exp_a[0] = 8'h44;
      check_b("R4 invalid address four-channel");
      check_a("R5 chain second frame");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule